// File: doc/BRIEF.md
# Instruction Word Prefetch Queue

This block sits between a word-wide instruction memory bus and an instruction decoder. It holds two words: the opcode register, which the decoder reads, and a one-word lookahead slot, which holds the word after it. It keeps a fetch address and reads words one at a time through a plain request/acknowledge port. Whenever the executing instruction takes a word, the block starts exactly one fetch to replace it. The opcode of the next instruction is therefore usually waiting in the lookahead slot when the current instruction ends.

The execution side sends two pulses. `step_op` moves the lookahead word into the opcode register when an instruction completes. `take_ext` passes the lookahead word out as an extension operand. A taken branch raises `redirect` with a target address. This empties both slots, drops any acknowledge in that cycle and restarts fetching at the target. The opcode register is filled first and the lookahead slot second. Reset works like a redirect to a parameter address.

Top module: `instr_prefetch_queue`

## Requirements
- R1: During and after reset, `op_valid` and `ext_valid` are 0, `fetch_req` is 1 and `fetch_addr` equals the `RESET_VEC` parameter.
- R2: `fetch_addr` advances by 2 (bytes per 16-bit word) on each cycle in which `fetch_req` and `fetch_ack` are both high and `redirect` is low. In every other cycle outside reset and redirect it holds its value.
- R3: A completed fetch loads the opcode register if it is empty, and otherwise loads the lookahead slot. Its data appears on `op_word` or `ext_word` on the following cycle.
- R4: Only one fetch is outstanding. `fetch_req` is low while both slots are full and high while either slot is empty.
- R5: `step_op` while `ext_valid` is 1 moves `ext_word` into `op_word` on the next cycle and empties the lookahead slot. This triggers one refill fetch.
- R6: `take_ext` while `ext_valid` is 1 (and `step_op` low) presents the operand on `ext_word` in that cycle, empties the lookahead slot and leaves `op_word` unchanged. This triggers one refill fetch.
- R7: `step_op` or `take_ext` while `ext_valid` is 0 is ignored, and `op_word` is unchanged by it.
- R8: `stall` is high in exactly the cycles where `step_op` or `take_ext` is high while `ext_valid` is 0.
- R9: When `step_op` and `take_ext` are high together, `step_op` wins and `take_ext` is ignored.
- R10: `redirect` empties both slots on the next cycle and sets `fetch_addr` to `redirect_addr`. An acknowledge in the redirect cycle is discarded and does not advance the address.
- R11: The lookahead slot is never full while the opcode register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect | input | 1 | Taken-branch flush pulse |
| redirect_addr | input | ADDR_W | Byte address at which to restart fetching |
| step_op | input | 1 | Instruction done: move lookahead word into opcode register |
| take_ext | input | 1 | Consume lookahead word as an extension operand |
| fetch_req | output | 1 | Word read request |
| fetch_addr | output | ADDR_W | Byte address of the requested word |
| fetch_ack | input | 1 | Read completes in this cycle |
| fetch_data | input | WORD_W | Read data, valid with `fetch_ack` |
| op_word | output | WORD_W | Opcode register contents |
| op_valid | output | 1 | Opcode register holds a fetched word |
| ext_word | output | WORD_W | Lookahead slot contents |
| ext_valid | output | 1 | Lookahead slot holds a fetched word |
| stall | output | 1 | A requested word is not yet available |

## Verification
Some properties are checked on every cycle: the address step and hold rules, the request being low exactly when both slots are full, the lookahead slot never being full ahead of the opcode register, the word movement after an accepted step, an unchanged opcode during a stall, and the emptying and new address after a redirect. Other behaviour only shows in the bench's scenarios, because it depends on the order of events: the first-opcode-then-lookahead fill order, `step_op` winning over `take_ext`, an acknowledge in the redirect cycle being thrown away (so no stale word appears), and an accepted request leaving exactly one refill fetch.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   // index of each storage slot; the fill order follows the index
   typedef enum logic [0:0] {
      SLOT_OP  = 1'b0,
      SLOT_EXT = 1'b1
   } slot_e;

   localparam int unsigned NUM_SLOTS = 2;

   function automatic int unsigned word_bytes(input int unsigned word_w);
      return word_w / 8;
   endfunction
endpackage

// File: rtl/pfq_slot.sv
module pfq_slot #(
   parameter int unsigned WORD_W     = 16,
   parameter bit          CLEAR_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   input  logic              drop,
   output logic              valid,
   output logic [WORD_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid <= 1'b0;
      else if (drop)
         valid <= 1'b0;
      else if (load)
         valid <= 1'b1;
   end

   generate
      if (CLEAR_DATA) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dout <= '0;
            else if (drop)
               dout <= '0;
            else if (load)
               dout <= din;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (load && !drop)
               dout <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl #(
   parameter int unsigned          ADDR_W    = 24,
   parameter int unsigned          STEP      = 2,
   parameter logic [ADDR_W-1:0]    RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] redirect_addr,
   input  logic              room,
   input  logic              ack,
   output logic              req,
   output logic [ADDR_W-1:0] addr,
   output logic              done
);
   localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

   assign req  = room;
   assign done = req && ack && !redirect;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= RESET_VEC;
      else if (redirect)
         addr <= redirect_addr;
      else if (done)
         addr <= addr + INC;
   end

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack && !redirect) |=> (addr == $past(addr) + INC));

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(req && ack) && !redirect) |=> $stable(addr));
endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue
   import pfq_pkg::*;
#(
   parameter int unsigned       WORD_W     = 16,
   parameter int unsigned       ADDR_W     = 24,
   parameter logic [ADDR_W-1:0] RESET_VEC  = 24'h000400,
   parameter bit                CLEAR_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] redirect_addr,
   input  logic              step_op,
   input  logic              take_ext,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_ack,
   input  logic [WORD_W-1:0] fetch_data,
   output logic [WORD_W-1:0] op_word,
   output logic              op_valid,
   output logic [WORD_W-1:0] ext_word,
   output logic              ext_valid,
   output logic              stall
);
   localparam int unsigned STEP = word_bytes(WORD_W);

   generate
      if (WORD_W < 8 || (WORD_W % 8) != 0) begin : g_bad_width
         $error("WORD_W must be a whole number of bytes");
      end
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if ((RESET_VEC % STEP) != 0) begin : g_bad_vec
         $error("RESET_VEC must be word aligned");
      end
   endgenerate

   logic              done;
   logic              step_ok, take_ok;
   logic              fill_op, fill_ext;
   logic              slot_load [NUM_SLOTS];
   logic              slot_drop [NUM_SLOTS];
   logic [WORD_W-1:0] slot_din  [NUM_SLOTS];
   logic              slot_vld  [NUM_SLOTS];
   logic [WORD_W-1:0] slot_dat  [NUM_SLOTS];

   assign op_valid  = slot_vld[SLOT_OP];
   assign ext_valid = slot_vld[SLOT_EXT];
   assign op_word   = slot_dat[SLOT_OP];
   assign ext_word  = slot_dat[SLOT_EXT];

   assign step_ok  = step_op && ext_valid && !redirect;
   assign take_ok  = take_ext && !step_op && ext_valid && !redirect;
   assign fill_op  = done && !op_valid;
   assign fill_ext = done && op_valid && !ext_valid;
   assign stall    = (step_op || take_ext) && !ext_valid;

   pfq_fetch_ctl #(
      .ADDR_W   (ADDR_W),
      .STEP     (STEP),
      .RESET_VEC(RESET_VEC)
   ) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .redirect     (redirect),
      .redirect_addr(redirect_addr),
      .room         (!(op_valid && ext_valid)),
      .ack          (fetch_ack),
      .req          (fetch_req),
      .addr         (fetch_addr),
      .done         (done)
   );

   always_comb begin
      slot_load[SLOT_OP]  = fill_op || step_ok;
      slot_din[SLOT_OP]   = step_ok ? ext_word : fetch_data;
      slot_drop[SLOT_OP]  = redirect;
      slot_load[SLOT_EXT] = fill_ext;
      slot_din[SLOT_EXT]  = fetch_data;
      slot_drop[SLOT_EXT] = redirect || step_ok || take_ok;
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      pfq_slot #(
         .WORD_W    (WORD_W),
         .CLEAR_DATA(CLEAR_DATA)
      ) u_slot (
         .clk  (clk),
         .rst_n(rst_n),
         .load (slot_load[s]),
         .din  (slot_din[s]),
         .drop (slot_drop[s]),
         .valid(slot_vld[s]),
         .dout (slot_dat[s])
      );
   end

   // R4
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && ext_valid) |-> !fetch_req);

   // R4
   refill_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_valid |-> fetch_req);

   // R11
   fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid |-> op_valid);

   // R5
   step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_op && ext_valid && !redirect) |=> (op_word == $past(ext_word)) && !ext_valid);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && op_valid && !redirect) |=> (op_word == $past(op_word)));

   // R10
   redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !op_valid && !ext_valid && (fetch_addr == $past(redirect_addr)));
endmodule

// File: tb/sim_instr_prefetch_queue.sv
module sim_instr_prefetch_queue;
   localparam int unsigned WORD_W = 16;
   localparam int unsigned ADDR_W = 24;
   localparam logic [ADDR_W-1:0] VEC = 24'h000400;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              redirect = 1'b0;
   logic [ADDR_W-1:0] redirect_addr = '0;
   logic              step_op = 1'b0;
   logic              take_ext = 1'b0;
   logic              fetch_req;
   logic [ADDR_W-1:0] fetch_addr;
   logic              fetch_ack = 1'b0;
   logic [WORD_W-1:0] fetch_data = '0;
   logic [WORD_W-1:0] op_word, ext_word;
   logic              op_valid, ext_valid, stall;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   instr_prefetch_queue #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .RESET_VEC(VEC)) u0 (
      .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_addr(redirect_addr),
      .step_op(step_op), .take_ext(take_ext), .fetch_req(fetch_req),
      .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
      .op_word(op_word), .op_valid(op_valid), .ext_word(ext_word),
      .ext_valid(ext_valid), .stall(stall)
   );

   typedef struct packed {
      logic        stp;
      logic        tk;
      logic        ack;
      logic [15:0] rd;
      logic        e_stall;
      logic        e_opv;
      logic        e_extv;
      logic        e_req;
      logic [23:0] e_addr;
      logic [15:0] e_op;
      logic [15:0] e_ext;
   } vec_t;

   // inputs for one cycle, then the state expected after its clock edge
   localparam vec_t TBL [10] = '{
      '{1'b0,1'b0,1'b1,16'hA001, 1'b0, 1'b1,1'b0,1'b1, 24'h000402, 16'hA001, 16'h0000},
      '{1'b0,1'b0,1'b0,16'h0000, 1'b0, 1'b1,1'b0,1'b1, 24'h000402, 16'hA001, 16'h0000},
      '{1'b1,1'b0,1'b0,16'h0000, 1'b1, 1'b1,1'b0,1'b1, 24'h000402, 16'hA001, 16'h0000},
      '{1'b0,1'b0,1'b1,16'hB002, 1'b0, 1'b1,1'b1,1'b0, 24'h000404, 16'hA001, 16'hB002},
      '{1'b0,1'b1,1'b0,16'h0000, 1'b0, 1'b1,1'b0,1'b1, 24'h000404, 16'hA001, 16'h0000},
      '{1'b0,1'b0,1'b1,16'hC003, 1'b0, 1'b1,1'b1,1'b0, 24'h000406, 16'hA001, 16'hC003},
      '{1'b1,1'b0,1'b0,16'h0000, 1'b0, 1'b1,1'b0,1'b1, 24'h000406, 16'hC003, 16'h0000},
      '{1'b1,1'b1,1'b1,16'hD004, 1'b1, 1'b1,1'b1,1'b0, 24'h000408, 16'hC003, 16'hD004},
      '{1'b1,1'b1,1'b0,16'h0000, 1'b0, 1'b1,1'b0,1'b1, 24'h000408, 16'hD004, 16'h0000},
      '{1'b0,1'b0,1'b1,16'hE005, 1'b0, 1'b1,1'b1,1'b0, 24'h00040A, 16'hD004, 16'hE005}
   };

   function automatic string row_tag(input int i);
      case (i)
         0: return "R3";
         1: return "R2";
         2: return "R7";
         3: return "R4";
         4: return "R6";
         5: return "R3";
         6: return "R5";
         7: return "R8";
         8: return "R9";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      step_op = 1'b0; take_ext = 1'b0; fetch_ack = 1'b0; fetch_data = '0; redirect = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!op_valid && !ext_valid, "R1", "valids in reset", {op_valid, ext_valid}, 0);
      chk(fetch_req && fetch_addr == VEC, "R1", "req/addr in reset", fetch_addr, VEC);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!op_valid && !ext_valid && fetch_addr == VEC, "R1", "after reset", fetch_addr, VEC);

      for (int i = 0; i < 10; i++) begin
         step_op = TBL[i].stp; take_ext = TBL[i].tk;
         fetch_ack = TBL[i].ack; fetch_data = TBL[i].rd;
         #1;
         chk(stall == TBL[i].e_stall, row_tag(i), $sformatf("row %0d stall", i), stall, TBL[i].e_stall);
         @(posedge clk);
         #1 idle();
         @(negedge clk);
         chk(op_valid == TBL[i].e_opv && ext_valid == TBL[i].e_extv, row_tag(i),
             $sformatf("row %0d valids", i), {op_valid, ext_valid}, {TBL[i].e_opv, TBL[i].e_extv});
         chk(fetch_req == TBL[i].e_req, row_tag(i), $sformatf("row %0d req", i), fetch_req, TBL[i].e_req);
         chk(fetch_addr == TBL[i].e_addr, row_tag(i), $sformatf("row %0d addr", i), fetch_addr, TBL[i].e_addr);
         chk(op_word == TBL[i].e_op, row_tag(i), $sformatf("row %0d op", i), op_word, TBL[i].e_op);
         if (TBL[i].e_extv)
            chk(ext_word == TBL[i].e_ext, row_tag(i), $sformatf("row %0d ext", i), ext_word, TBL[i].e_ext);
      end

      // R6: operand visible in the take cycle, then slot empties
      take_ext = 1'b1;
      #1 chk(ext_word == 16'hE005 && ext_valid, "R6", "operand in take cycle", ext_word, 16'hE005);
      @(posedge clk); #1 idle();
      @(negedge clk);
      chk(!ext_valid && fetch_req && op_word == 16'hD004, "R6", "after take", op_word, 16'hD004);

      // R10: redirect with an acknowledge in the same cycle
      redirect = 1'b1; redirect_addr = 24'h000800; fetch_ack = 1'b1; fetch_data = 16'hFFFF;
      @(posedge clk); #1 idle();
      @(negedge clk);
      chk(!op_valid && !ext_valid, "R10", "slots emptied", {op_valid, ext_valid}, 0);
      chk(fetch_addr == 24'h000800 && fetch_req, "R10", "restart address", fetch_addr, 24'h000800);

      // R3: opcode register first, then lookahead slot
      fetch_ack = 1'b1; fetch_data = 16'h1111;
      @(posedge clk); #1 idle();
      @(negedge clk);
      chk(op_valid && !ext_valid && op_word == 16'h1111, "R3", "first word to opcode", op_word, 16'h1111);
      fetch_ack = 1'b1; fetch_data = 16'h2222;
      @(posedge clk); #1 idle();
      @(negedge clk);
      chk(ext_valid && ext_word == 16'h2222 && op_word == 16'h1111, "R3", "second word to lookahead",
          ext_word, 16'h2222);
      chk(fetch_addr == 24'h000804 && !fetch_req, "R4", "full queue idles bus", fetch_addr, 24'h000804);

      // R4: ack while full is ignored
      fetch_ack = 1'b1; fetch_data = 16'h3333;
      @(posedge clk); #1 idle();
      @(negedge clk);
      chk(fetch_addr == 24'h000804 && ext_word == 16'h2222, "R4", "ack without req", ext_word, 16'h2222);

      // R1: reset mid-stream returns to the vector
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!op_valid && !ext_valid && fetch_addr == VEC, "R1", "re-reset", fetch_addr, VEC);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule